// File: doc/BRIEF.md
# Reset and Mode-Select Pin Controller

This block owns two shared pads that matter around reset. Pad A is either a plain general-purpose input or an active-low external reset input. Pad B is either a debug/mode-select pin or a general-purpose pin. When the chip's internal reset is released, the block may sample pad B. A low level puts the device into a debug-halted state and a high level into normal run. Sampling happens only when the reset was a power-on reset or a debug-requested forced reset. After any other reset the device always comes up in run mode.

The block also holds the two pin-function enables. The reset-function enable for pad A is sticky: once set, it stays set until the next power-on reset. It also comes up set on its own after a power-on reset that selected debug mode. The debug-function enable for pad B is forced set by every reset, and software may clear or set it at other times. Both enables drive pad pullups. The block issues a reset request when the synchronised pad A level is low with the reset function enabled, and also on a forced-reset request. Debug mode is entered at run time by a serial background command, by the background instruction or by a breakpoint hit. A resume request leaves debug mode. All control pins are plain level or pulse signals with no handshake.

Top module: `rmp_top`

## Requirements
- R1: After a power-on reset whose release samples pad B high, `dbg_mode` is 0 and `pin_a_rst` is 0.
- R2: After a power-on reset whose release samples pad B low, `dbg_mode` is 1 and `pin_a_rst` is 1. The effect appears on the clock edge where `int_rst_n` is first seen high, and pad B must be stable for at least two cycles before that edge.
- R3: A write with `wr_rst_pin_en`=1 sets `pin_a_rst`, and later writes of 0 leave it at 1. Only `por_n` low clears it.
- R4: While `pin_a_rst` is 1, `pull_a_en` is 1, and a low on `pad_a_in` raises `rst_req` two clock edges later through a two-flop synchronizer. While `pin_a_rst` is 0, pad A has no effect on `rst_req`, and `pull_a_en` follows `gp_pull_a`.
- R5: `pin_b_dbg` is forced to 1 on every cycle that `int_rst_n` is low. Outside reset, a write loads it from `wr_dbg_pin_en` on the next edge.
- R6: `pull_b_en` is 1 while `pin_b_dbg` is 1. Otherwise it follows `gp_pull_b`.
- R7: At the release of reset, pad B is sampled only if a power-on reset or a `force_rst_req` pulse has occurred since the previous release. For any other reset, `dbg_mode` is 0 after release whatever level pad B has.
- R8: Outside reset, a pulse on `bg_cmd`, `bg_insn` or `bkpt_hit` sets `dbg_mode` on the next edge, and `dbg_go` clears it. When an entry event and `dbg_go` arrive together, the entry event wins.
- R9: `force_rst_req` drives `rst_req` high in the same cycle.
- R10: While `int_rst_n` is low, `dbg_mode` is 0. Register writes and debug entry events in those cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| int_rst_n | input | 1 | Chip internal reset, active low, synchronous to clk |
| force_rst_req | input | 1 | Debug-requested forced reset pulse |
| pad_a_in | input | 1 | Pad A input level |
| pad_b_in | input | 1 | Pad B (mode select) input level |
| wr_en | input | 1 | Register write strobe |
| wr_rst_pin_en | input | 1 | Write data: pad A reset-function enable |
| wr_dbg_pin_en | input | 1 | Write data: pad B debug-function enable |
| gp_pull_a | input | 1 | General-purpose pullup request for pad A |
| gp_pull_b | input | 1 | General-purpose pullup request for pad B |
| bg_cmd | input | 1 | Serial background command received |
| bg_insn | input | 1 | Background instruction executed |
| bkpt_hit | input | 1 | Breakpoint match |
| dbg_go | input | 1 | Resume from debug mode |
| rst_req | output | 1 | Reset request to the chip reset controller |
| dbg_mode | output | 1 | Debug-halted mode flag |
| pin_a_rst | output | 1 | Pad A works as reset input |
| pin_b_dbg | output | 1 | Pad B works as debug/mode-select pin |
| pull_a_en | output | 1 | Pad A pullup enable |
| pull_b_en | output | 1 | Pad B pullup enable |

## Verification
`rst_req` answers `force_rst_req` in the same cycle. It follows a pad A low two edges later, because of the synchronizer. Writes, debug events and the effects of a reset release all show up one edge after the input is seen. The bench drives inputs on the falling clock edge and updates its behavioural model on the rising edge from those same values. It then compares every output on the following falling edge, so each result is checked in exactly the cycle it becomes due. Directed checks also sample the synchronizer one edge early to confirm that the two-stage delay is exact.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
  // Number of flops in each pad synchronizer chain
  localparam int unsigned SYNC_STAGES = 2;
  // Pads handled by the shared synchronizer
  localparam int unsigned PAD_COUNT   = 2;
  localparam int unsigned PAD_A       = 0;
  localparam int unsigned PAD_B       = 1;

  typedef struct packed {
    logic rst_fn;   // pad A acts as reset input
    logic dbg_fn;   // pad B acts as debug/mode-select
  } pin_sel_t;
endpackage

// File: rtl/rmp_sync.sv
module rmp_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stg[s] <= RST_VAL;
          else        stg[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/rmp_mode_ctl.sv
module rmp_mode_ctl (
  input  logic clk,
  input  logic por_n,
  input  logic int_rst_n,
  input  logic force_rst_req,
  input  logic ms_level,      // synchronised pad B
  input  logic bg_cmd,
  input  logic bg_insn,
  input  logic bkpt_hit,
  input  logic dbg_go,
  output logic release_evt,   // first cycle int_rst_n seen high
  output logic por_dbg_entry, // release after POR with pad B low
  output logic dbg_mode
);
  logic rel_q;       // int_rst_n seen on previous edge
  logic armed_q;     // mode sampling enabled for next release
  logic por_pend_q;  // no release since power-on
  logic mode_q;
  logic entry;

  assign release_evt   = int_rst_n & ~rel_q;
  assign entry         = bg_cmd | bg_insn | bkpt_hit;
  assign por_dbg_entry = release_evt & por_pend_q & ~ms_level;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rel_q      <= 1'b0;
      armed_q    <= 1'b1;
      por_pend_q <= 1'b1;
    end else begin
      rel_q <= int_rst_n;
      if (force_rst_req)    armed_q <= 1'b1;
      else if (release_evt) armed_q <= 1'b0;
      if (release_evt)      por_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           mode_q <= 1'b0;
    else if (!int_rst_n)  mode_q <= 1'b0;
    else if (release_evt) mode_q <= armed_q & ~ms_level;
    else if (entry)       mode_q <= 1'b1;
    else if (dbg_go)      mode_q <= 1'b0;
  end

  assign dbg_mode = mode_q;

  AST_RUN_AFTER_OTHER_RST: assert property (@(posedge clk) disable iff (!por_n)
    (release_evt && !armed_q) |=> !dbg_mode) else $error("run mode expected"); // R7

  AST_ENTRY_SETS_MODE: assert property (@(posedge clk) disable iff (!por_n)
    (int_rst_n && rel_q && entry) |=> dbg_mode) else $error("entry lost"); // R8

  AST_RST_CLEARS_MODE: assert property (@(posedge clk) disable iff (!por_n)
    (!int_rst_n) |=> (!dbg_mode || $past(release_evt) == 1'b0 && int_rst_n && rel_q == 1'b0)) else $error("mode during reset"); // R10
endmodule

// File: rtl/rmp_pin_en.sv
module rmp_pin_en (
  input  logic clk,
  input  logic por_n,
  input  logic int_rst_n,
  input  logic por_dbg_entry,
  input  logic wr_en,
  input  logic wr_rst_pin_en,
  input  logic wr_dbg_pin_en,
  input  logic gp_pull_a,
  input  logic gp_pull_b,
  output rmp_pkg::pin_sel_t sel,
  output logic pull_a_en,
  output logic pull_b_en
);
  logic rst_fn_q;
  logic dbg_fn_q;
  logic wr_ok;

  assign wr_ok = wr_en & int_rst_n;

  // Sticky reset-function enable: only power-on clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                              rst_fn_q <= 1'b0;
    else if (por_dbg_entry)                  rst_fn_q <= 1'b1;
    else if (wr_ok && wr_rst_pin_en)         rst_fn_q <= 1'b1;
  end

  // Debug-function enable: re-armed by any reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          dbg_fn_q <= 1'b1;
    else if (!int_rst_n) dbg_fn_q <= 1'b1;
    else if (wr_ok)      dbg_fn_q <= wr_dbg_pin_en;
  end

  assign sel.rst_fn = rst_fn_q;
  assign sel.dbg_fn = dbg_fn_q;
  assign pull_a_en  = rst_fn_q | gp_pull_a;
  assign pull_b_en  = dbg_fn_q | gp_pull_b;

  AST_RST_FN_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    rst_fn_q |=> rst_fn_q) else $error("reset enable cleared"); // R3

  AST_DBG_FN_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    (!int_rst_n) |=> dbg_fn_q) else $error("debug enable not forced"); // R5

  AST_WR_IGNORED_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    (!int_rst_n && !por_dbg_entry) |=> $stable(rst_fn_q)) else $error("write in reset"); // R10
endmodule

// File: rtl/rmp_top.sv
module rmp_top (
  input  logic clk,
  input  logic por_n,
  input  logic int_rst_n,
  input  logic force_rst_req,
  input  logic pad_a_in,
  input  logic pad_b_in,
  input  logic wr_en,
  input  logic wr_rst_pin_en,
  input  logic wr_dbg_pin_en,
  input  logic gp_pull_a,
  input  logic gp_pull_b,
  input  logic bg_cmd,
  input  logic bg_insn,
  input  logic bkpt_hit,
  input  logic dbg_go,
  output logic rst_req,
  output logic dbg_mode,
  output logic pin_a_rst,
  output logic pin_b_dbg,
  output logic pull_a_en,
  output logic pull_b_en
);
  import rmp_pkg::*;

  logic [PAD_COUNT-1:0] pad_raw;
  logic [PAD_COUNT-1:0] pad_s;
  logic release_evt;
  logic por_dbg_entry;
  pin_sel_t sel;

  assign pad_raw[PAD_A] = pad_a_in;
  assign pad_raw[PAD_B] = pad_b_in;

  rmp_sync #(.WIDTH(PAD_COUNT), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .por_n(por_n),
    .din  (pad_raw),
    .dout (pad_s)
  );

  rmp_mode_ctl u_mode (
    .clk          (clk),
    .por_n        (por_n),
    .int_rst_n    (int_rst_n),
    .force_rst_req(force_rst_req),
    .ms_level     (pad_s[PAD_B]),
    .bg_cmd       (bg_cmd),
    .bg_insn      (bg_insn),
    .bkpt_hit     (bkpt_hit),
    .dbg_go       (dbg_go),
    .release_evt  (release_evt),
    .por_dbg_entry(por_dbg_entry),
    .dbg_mode     (dbg_mode)
  );

  rmp_pin_en u_pin (
    .clk          (clk),
    .por_n        (por_n),
    .int_rst_n    (int_rst_n),
    .por_dbg_entry(por_dbg_entry),
    .wr_en        (wr_en),
    .wr_rst_pin_en(wr_rst_pin_en),
    .wr_dbg_pin_en(wr_dbg_pin_en),
    .gp_pull_a    (gp_pull_a),
    .gp_pull_b    (gp_pull_b),
    .sel          (sel),
    .pull_a_en    (pull_a_en),
    .pull_b_en    (pull_b_en)
  );

  assign pin_a_rst = sel.rst_fn;
  assign pin_b_dbg = sel.dbg_fn;
  assign rst_req   = (sel.rst_fn & ~pad_s[PAD_A]) | force_rst_req;

  AST_PAD_A_NEEDS_FN: assert property (@(posedge clk) disable iff (!por_n)
    (!pin_a_rst && !force_rst_req) |-> !rst_req) else $error("pad A leaked"); // R4

  AST_POR_DBG_ENABLES_RST: assert property (@(posedge clk) disable iff (!por_n)
    por_dbg_entry |=> (pin_a_rst && dbg_mode)) else $error("debug power-on defaults"); // R2

  AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (!por_n)
    release_evt |=> !release_evt) else $error("double release"); // R7
endmodule

// File: tb/tb_rmp_top.sv
module tb_rmp_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n = 1'b0, int_rst_n = 1'b0, force_rst_req = 1'b0;
  logic pad_a_in = 1'b1, pad_b_in = 1'b1;
  logic wr_en = 1'b0, wr_rst_pin_en = 1'b0, wr_dbg_pin_en = 1'b0;
  logic gp_pull_a = 1'b0, gp_pull_b = 1'b0;
  logic bg_cmd = 1'b0, bg_insn = 1'b0, bkpt_hit = 1'b0, dbg_go = 1'b0;
  logic rst_req, dbg_mode, pin_a_rst, pin_b_dbg, pull_a_en, pull_b_en;

  rmp_top dut (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // Behavioural reference model
  bit m_rst_fn, m_dbg_fn, m_mode, m_armed, m_por_pend, m_prev_rel;
  bit qa[$], qb[$];

  function automatic void model_por();
    m_rst_fn = 0; m_dbg_fn = 1; m_mode = 0; m_armed = 1; m_por_pend = 1; m_prev_rel = 0;
    qa = '{1, 1}; qb = '{1, 1};
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) model_por();
    else begin
      bit ms, rel, ev;
      ms = qb[0];
      rel = int_rst_n && !m_prev_rel;
      ev = bg_cmd || bg_insn || bkpt_hit;
      if (!int_rst_n) begin
        m_dbg_fn = 1; m_mode = 0;
      end else begin
        if (rel) begin
          m_mode = m_armed && !ms;
          if (m_por_pend && !ms) m_rst_fn = 1;
          m_por_pend = 0;
        end else if (ev) m_mode = 1;
        else if (dbg_go) m_mode = 0;
        if (wr_en) begin
          if (wr_rst_pin_en) m_rst_fn = 1;
          m_dbg_fn = wr_dbg_pin_en;
        end
      end
      if (force_rst_req) m_armed = 1;
      else if (rel) m_armed = 0;
      m_prev_rel = int_rst_n;
      void'(qa.pop_front()); qa.push_back(pad_a_in);
      void'(qb.pop_front()); qb.push_back(pad_b_in);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (por_n && !finished) begin
      chk("R4/R9 rst_req", rst_req, (m_rst_fn && !qa[0]) || force_rst_req);
      chk("R8 dbg_mode", dbg_mode, m_mode);
      chk("R3 pin_a_rst", pin_a_rst, m_rst_fn);
      chk("R5 pin_b_dbg", pin_b_dbg, m_dbg_fn);
      chk("R4 pull_a_en", pull_a_en, m_rst_fn || gp_pull_a);
      chk("R6 pull_b_en", pull_b_en, m_dbg_fn || gp_pull_b);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_por(logic ms);
    @(negedge clk); por_n = 0; int_rst_n = 0; pad_b_in = ms;
    step(2); por_n = 1; step(4);
    int_rst_n = 1; step(1);
  endtask

  task automatic write(logic r, logic d);
    wr_en = 1; wr_rst_pin_en = r; wr_dbg_pin_en = d; step(1);
    wr_en = 0; wr_rst_pin_en = 0; wr_dbg_pin_en = 0;
  endtask

  initial begin
    step(1);
    chk("R1 reset state pin_a_rst", pin_a_rst, 0);
    chk("R5 reset state pin_b_dbg", pin_b_dbg, 1);
    do_por(1'b1);
    step(1);
    chk("R1 run after POR", dbg_mode, 0);
    chk("R1 pad A is GPI", pin_a_rst, 0);
    // pad A low without the function: ignored
    pad_a_in = 0; step(3);
    chk("R4 pad A ignored", rst_req, 0);
    pad_a_in = 1; step(3);
    // pullups via general requests
    gp_pull_a = 1; step(1); chk("R4 gp pull a", pull_a_en, 1); gp_pull_a = 0;
    write(1, 0); step(1);
    chk("R3 set reset fn", pin_a_rst, 1);
    chk("R5 debug fn cleared", pin_b_dbg, 0);
    chk("R4 forced pull a", pull_a_en, 1);
    gp_pull_b = 1; step(1); chk("R6 gp pull b", pull_b_en, 1);
    gp_pull_b = 0; step(1); chk("R6 no pull b", pull_b_en, 0);
    write(0, 0); step(1);
    chk("R3 sticky", pin_a_rst, 1);
    // external reset through the synchronizer
    pad_a_in = 0; step(1);
    chk("R4 one edge early", rst_req, 0);
    step(1);
    chk("R4 two edges", rst_req, 1);
    int_rst_n = 0; pad_b_in = 0; step(1);
    chk("R5 forced by reset", pin_b_dbg, 1);
    pad_a_in = 1; step(4);
    int_rst_n = 1; step(1);
    chk("R7 pin reset ignores MS", dbg_mode, 0);
    chk("R3 kept over reset", pin_a_rst, 1);
    pad_b_in = 1; step(3);
    // debug entry/exit
    bg_cmd = 1; step(1); bg_cmd = 0; chk("R8 bg cmd", dbg_mode, 1);
    dbg_go = 1; step(1); dbg_go = 0; chk("R8 go", dbg_mode, 0);
    dbg_go = 1; bkpt_hit = 1; step(1); dbg_go = 0; bkpt_hit = 0;
    chk("R8 entry beats go", dbg_mode, 1);
    dbg_go = 1; step(1); dbg_go = 0;
    bg_insn = 1; step(1); bg_insn = 0; chk("R8 bg insn", dbg_mode, 1);
    dbg_go = 1; step(1); dbg_go = 0;
    // forced reset: same-cycle request, then sampled release
    pad_b_in = 0; step(3);
    force_rst_req = 1; #1; chk("R9 same cycle", rst_req, 1);
    step(1); force_rst_req = 0; int_rst_n = 0; step(1);
    wr_en = 1; wr_dbg_pin_en = 0; bg_cmd = 1; step(1);
    wr_en = 0; bg_cmd = 0;
    chk("R10 write ignored", pin_b_dbg, 1);
    chk("R10 event ignored", dbg_mode, 0);
    step(2); int_rst_n = 1; step(1);
    chk("R7 force reset samples MS", dbg_mode, 1);
    // POR into debug
    do_por(1'b0);
    chk("R2 debug after POR", dbg_mode, 1);
    chk("R2 reset fn default", pin_a_rst, 1);
    // POR back to run clears the sticky bit
    @(negedge clk); por_n = 0; #1;
    chk("R3 POR clears", pin_a_rst, 0);
    do_por(1'b1);
    chk("R1 run again", dbg_mode, 0);
    chk("R1 GPI again", pin_a_rst, 0);
    step(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule